// File: doc/BRIEF.md
# Position Counter with Rate-Limited Quadrature Output

This block sits behind an interpolator that reports motion as single position steps, each with a direction. It keeps a signed 28-bit running position, which can be zeroed either by a rising edge of a reference-mark level or by an explicit zero command. A trigger pulse copies the current position into a small first-in first-out capture store that holds two entries. The consumer drains the store at its own pace through a read strobe.

The same steps are replayed as a pair of square waves a quarter period apart, in the usual incremental-encoder style, plus an index pulse for the reference mark. Downstream receivers cannot accept edges at full clock rate, so a selectable minimum spacing of 1 to 128 clock periods is enforced between output edges. Steps that arrive faster than that are queued in a signed backlog counter. If the backlog would leave its range, a sticky overflow flag is raised.

Top module: `quad_poscnt`

## Requirements
- R1: Each cycle with `step_vld` high changes `count` by one on the next clock edge: up when `step_dir` is 1 and down when it is 0. The value is 28-bit two's complement and wraps, so one step down from 0 gives 0xFFFFFFF.
- R2: `zero_cmd` high clears `count` to 0 on the next edge, and it takes priority over a step in the same cycle.
- R3: `ref_lvl` passes through a two-flop synchroniser. Only a rising edge clears `count`, three edges after the input rises, and `qz` is high for exactly that one cycle. A level held high does not clear the count again.
- R4: `trig` high copies the value `count` had before that edge into the capture store. `buf_vld` is high while the store is not empty, and `buf_count` shows the oldest entry.
- R5: `buf_rd` high removes the oldest entry, and a read of an empty store has no effect. A trigger and a read in the same cycle with one entry stored replace that entry with the new capture.
- R6: A trigger while both entries are full discards the oldest entry and keeps the newer one plus the new capture.
- R7: The output pair {`qa`,`qb`} runs 00→01→11→10→00 for forward steps and in reverse for backward steps. At most one of the two changes per clock. Both are 0 after reset.
- R8: Consecutive output edges are at least 2^`itv_sel` clock periods apart. When the output has been idle, the first edge appears on the edge after the step is registered.
- R9: Queued steps are held in an 8-bit signed backlog. A step that would push the backlog outside −128..127 is dropped, and `ovf` is set and stays set until reset.
- R10: After reset `count` is 0, the store is empty, `qa`, `qb`, `qz` and `ovf` are 0, and the backlog is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_vld | input | 1 | One position step this cycle |
| step_dir | input | 1 | Step direction, 1 = forward |
| ref_lvl | input | 1 | Reference-mark level, asynchronous |
| zero_cmd | input | 1 | Clear the position counter |
| trig | input | 1 | Capture the position into the store |
| itv_sel | input | 3 | Minimum edge spacing exponent |
| buf_rd | input | 1 | Remove the oldest stored capture |
| count | output | 28 | Live position |
| buf_count | output | 28 | Oldest stored capture |
| buf_vld | output | 1 | Store not empty |
| qa | output | 1 | Quadrature channel A |
| qb | output | 1 | Quadrature channel B |
| qz | output | 1 | Index pulse on reference rising edge |
| ovf | output | 1 | Sticky backlog overflow |

## Verification
The assertions check the following on every clock:
- the spacing between output edges against the interval that was selected when the previous edge was made;
- that only one quadrature channel changes per clock;
- the stickiness of the overflow flag;
- the one-cycle width of the index pulse;
- clearing of the counter by command;
- that the count holds when neither a step nor a clear is present.

Only the bench scenarios can show the rest:
- the exact Gray order and the edge latency;
- the three-edge reference timing;
- the store's order of entries, the overwrite and the simultaneous push and pop;
- the point at which a sustained burst overflows the backlog.

// File: rtl/quad_poscnt.sv
module quad_poscnt #(
  parameter int CW  = 28,
  parameter int BLW = 8,
  parameter int SW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_vld,
  input  logic          step_dir,
  input  logic          ref_lvl,
  input  logic          zero_cmd,
  input  logic          trig,
  input  logic [SW-1:0] itv_sel,
  input  logic          buf_rd,
  output logic [CW-1:0] count,
  output logic [CW-1:0] buf_count,
  output logic          buf_vld,
  output logic          qa,
  output logic          qb,
  output logic          qz,
  output logic          ovf
);
  localparam int TW = (1 << SW) - 1;
  localparam int SUMW = BLW + 2;
  localparam logic signed [SUMW-1:0] BL_HI = SUMW'((1 << (BLW - 1)) - 1);
  localparam logic signed [SUMW-1:0] BL_LO = ~BL_HI;

  // reference synchroniser and edge detect
  logic [2:0] ref_sh;
  logic       ref_rise;
  assign ref_rise = ref_sh[1] & ~ref_sh[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ref_sh <= '0;
      qz     <= 1'b0;
    end else begin
      ref_sh <= {ref_sh[1:0], ref_lvl};
      qz     <= ref_rise;
    end
  end

  // position counter
  always_ff @(posedge clk) begin
    if (!rst_n)                    count <= '0;
    else if (zero_cmd || ref_rise) count <= '0;
    else if (step_vld)             count <= step_dir ? count + 1'b1 : count - 1'b1;
  end

  // two-entry capture store
  logic [CW-1:0] ent1;
  logic [1:0]    fill;
  logic          pop;
  assign pop     = buf_rd && (fill != 2'd0);
  assign buf_vld = (fill != 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_count <= '0;
      ent1      <= '0;
      fill      <= 2'd0;
    end else if (trig) begin
      case (fill)
        2'd0: begin
          buf_count <= count;
          fill      <= 2'd1;
        end
        2'd1: begin
          if (pop) buf_count <= count;
          else begin
            ent1 <= count;
            fill <= 2'd2;
          end
        end
        default: begin
          buf_count <= ent1;
          ent1      <= count;
        end
      endcase
    end else if (pop) begin
      buf_count <= ent1;
      fill      <= fill - 2'd1;
    end
  end

  // rate-limited quadrature regeneration
  logic signed [BLW-1:0]  bl;
  logic        [TW-1:0]   tmr;
  logic        [1:0]      ph;
  logic                   emit;
  logic signed [SUMW-1:0] inc, dec, sum, bl_n;
  logic        [TW:0]     span;
  logic                   out_of_range;

  assign emit = (tmr == '0) && (bl != '0);
  assign inc  = !step_vld ? '0 : (step_dir ? SUMW'(1) : '1);
  assign dec  = !emit ? '0 : (bl[BLW-1] ? '1 : SUMW'(1));
  assign sum  = SUMW'(bl) + inc - dec;
  assign out_of_range = (sum > BL_HI) || (sum < BL_LO);
  assign bl_n = out_of_range ? sum - inc : sum;
  assign span = (TW + 1)'(1) << itv_sel;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bl  <= '0;
      tmr <= '0;
      ph  <= 2'd0;
      ovf <= 1'b0;
    end else begin
      bl <= bl_n[BLW-1:0];
      if (out_of_range) ovf <= 1'b1;
      if (emit) begin
        tmr <= TW'(span - 1'b1);
        ph  <= bl[BLW-1] ? ph - 2'd1 : ph + 2'd1;
      end else if (tmr != '0) begin
        tmr <= tmr - 1'b1;
      end
    end
  end

  assign qa = ph[1];
  assign qb = ph[1] ^ ph[0];
endmodule

// File: rtl/quad_poscnt_chk.sv
module quad_poscnt_chk #(
  parameter int CW = 28,
  parameter int SW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          step_vld,
  input logic          zero_cmd,
  input logic [SW-1:0] itv_sel,
  input logic [CW-1:0] count,
  input logic          qa,
  input logic          qb,
  input logic          qz,
  input logic          ovf
);
  logic [1:0]  prev_q;
  logic [SW-1:0] sel_d;
  logic [8:0]  gap;
  logic [8:0]  need;
  logic        chg;
  assign chg = ({qa, qb} != prev_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 2'b00;
      sel_d  <= '0;
      gap    <= 9'h1FF;
      need   <= '0;
    end else begin
      prev_q <= {qa, qb};
      sel_d  <= itv_sel;
      if (chg) begin
        gap  <= 9'd1;
        need <= 9'd1 << sel_d;
      end else if (gap != 9'h1FF) begin
        gap <= gap + 9'd1;
      end
    end
  end

  assert_edge_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> (gap >= need));

  assert_one_channel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({qa, qb} ^ prev_q) <= 1);

  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  assert_index_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    qz |=> !qz);

  assert_zero_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    zero_cmd |=> (count == '0));

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_vld && !zero_cmd) |=> ((count == $past(count)) || (count == '0)));
endmodule

bind quad_poscnt quad_poscnt_chk #(.CW(CW), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_vld(step_vld), .zero_cmd(zero_cmd),
  .itv_sel(itv_sel), .count(count), .qa(qa), .qb(qb), .qz(qz), .ovf(ovf)
);

// File: tb/test_quad_poscnt.sv
module test_quad_poscnt;
  logic        clk = 1'b0;
  logic        rst_n, step_vld, step_dir, ref_lvl, zero_cmd, trig, buf_rd;
  logic [2:0]  itv_sel;
  logic [27:0] count, buf_count;
  logic        buf_vld, qa, qb, qz, ovf;
  int          errors = 0;
  int          checks = 0;

  always #4 clk = ~clk;

  quad_poscnt i_quad_poscnt (
    .clk(clk), .rst_n(rst_n), .step_vld(step_vld), .step_dir(step_dir),
    .ref_lvl(ref_lvl), .zero_cmd(zero_cmd), .trig(trig), .itv_sel(itv_sel),
    .buf_rd(buf_rd), .count(count), .buf_count(buf_count), .buf_vld(buf_vld),
    .qa(qa), .qb(qb), .qz(qz), .ovf(ovf)
  );

  // {step_vld, step_dir, zero_cmd, expected count after the edge}
  localparam logic [30:0] VEC [10] = '{
    {3'b110, 28'd1},        {3'b110, 28'd2},        {3'b100, 28'd1},
    {3'b000, 28'd1},        {3'b100, 28'd0},        {3'b100, 28'hFFFFFFF},
    {3'b100, 28'hFFFFFFE},  {3'b111, 28'd0},        {3'b110, 28'd1},
    {3'b001, 28'd0}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; step_vld = 0; step_dir = 0; ref_lvl = 0; zero_cmd = 0;
    trig = 0; buf_rd = 0; itv_sel = 3'd0;
    tick(); tick();
    rst_n = 1'b1;
  endtask

  task automatic steps(input int n, input logic dir);
    step_vld = 1'b1; step_dir = dir;
    repeat (n) tick();
    step_vld = 1'b0;
  endtask

  task automatic wait_edge(input int lim, output int n);
    logic [1:0] p;
    p = {qa, qb};
    n = 0;
    while ({qa, qb} == p && n < lim) begin
      tick();
      n++;
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    do_reset();
    // R10 reset state
    chk("R10 count", 32'(count), 0);
    chk("R10 buf_vld", 32'(buf_vld), 0);
    chk("R10 qa qb qz ovf", {28'd0, qa, qb, qz, ovf}, 0);

    // R1 R2 table walk
    for (int i = 0; i < 10; i++) begin
      {step_vld, step_dir, zero_cmd} = VEC[i][30:28];
      tick();
      chk("R1/R2 table", 32'(count), 32'(VEC[i][27:0]));
    end
    zero_cmd = 0; step_vld = 0;

    // R3 reference rising edge
    steps(5, 1'b1);
    ref_lvl = 1'b1;
    tick(); tick();
    chk("R3 count before sync", 32'(count), 5);
    tick();
    chk("R3 count cleared", 32'(count), 0);
    chk("R3 qz pulse", 32'(qz), 1);
    tick();
    chk("R3 qz one cycle", 32'(qz), 0);
    steps(1, 1'b1);
    tick(); tick();
    chk("R3 level no reclear", 32'(count), 1);
    ref_lvl = 1'b0;

    // R4 R5 R6 capture store
    do_reset();
    buf_rd = 1'b1; tick(); buf_rd = 1'b0;
    chk("R5 read empty", 32'(buf_vld), 0);
    steps(3, 1'b1);
    trig = 1; tick(); trig = 0;
    chk("R4 vld", 32'(buf_vld), 1);
    chk("R4 value", 32'(buf_count), 3);
    steps(1, 1'b1);
    trig = 1; tick(); trig = 0;
    steps(1, 1'b1);
    trig = 1; tick(); trig = 0;
    chk("R6 oldest dropped", 32'(buf_count), 4);
    buf_rd = 1; tick();
    chk("R6 second entry", 32'(buf_count), 5);
    tick(); buf_rd = 0;
    chk("R5 drained", 32'(buf_vld), 0);
    trig = 1; tick(); trig = 0;
    steps(1, 1'b1);
    trig = 1; buf_rd = 1; tick(); trig = 0; buf_rd = 0;
    chk("R5 push+pop value", 32'(buf_count), 6);
    chk("R5 push+pop vld", 32'(buf_vld), 1);
    buf_rd = 1; tick(); buf_rd = 0;
    chk("R5 single entry", 32'(buf_vld), 0);

    // R7 R8 quadrature, spacing 4
    do_reset();
    itv_sel = 3'd2;
    steps(3, 1'b1);
    chk("R7 first state", {30'd0, qa, qb}, 32'b01);
    wait_edge(20, n);
    chk("R8 gap 4 (a)", 32'(n), 3);
    chk("R7 second state", {30'd0, qa, qb}, 32'b11);
    wait_edge(20, n);
    chk("R8 gap 4 (b)", 32'(n), 4);
    chk("R7 third state", {30'd0, qa, qb}, 32'b10);
    wait_edge(20, n);
    chk("R8 backlog empty", 32'(n), 20);
    steps(1, 1'b0);
    tick();
    chk("R7 reverse", {30'd0, qa, qb}, 32'b11);
    tick(); tick(); tick(); tick();
    itv_sel = 3'd0;
    steps(1, 1'b1);
    step_vld = 1; tick(); step_vld = 0;
    chk("R7 forward 10", {30'd0, qa, qb}, 32'b10);
    tick();
    chk("R8 spacing 1", {30'd0, qa, qb}, 32'b00);

    // R8 spacing 128
    do_reset();
    itv_sel = 3'd7;
    steps(2, 1'b1);
    chk("R8 first edge", {30'd0, qa, qb}, 32'b01);
    wait_edge(300, n);
    chk("R8 gap 128", 32'(n), 128);

    // R9 overflow
    do_reset();
    itv_sel = 3'd7;
    steps(100, 1'b1);
    chk("R9 no overflow yet", 32'(ovf), 0);
    steps(100, 1'b1);
    chk("R9 overflow", 32'(ovf), 1);
    chk("R1 count unaffected", 32'(count), 200);
    tick(); tick();
    chk("R9 sticky", 32'(ovf), 1);
    do_reset();
    chk("R10 ovf cleared", 32'(ovf), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule